// File: doc/BRIEF.md
# Layer-Interleaved Parity Stripe Address Mapper

This block produces the list of physical page locations that together form one parity stripe spread over a set of flash chips. A controller pulses a start input with a stripe number. The block then emits one member address per accepted valid/ready handshake, in ascending chip order. Each address carries the chip number, the block inside that chip, the wordline layer and the page type (upper/MSB or lower/LSB). The final member is the parity page and is marked with a last flag.

Pages on middle layers and MSB pages fail more often than the rest. The placement therefore rotates the layer with the chip number and alternates the page type from chip to chip. As a result, a stripe never collects only the weakest pages and never stacks many members on one layer. No page is added beyond the single parity member of a conventional stripe.

Stripes are grouped in runs of 2L, where L is the layer count. The two halves of a run use opposite page-type phases, so each run fills every (layer, page type) slot of one block in every chip exactly once.

Top module: `rl_stripe_mapper`

## Requirements
- R1: After reset, `mem_valid_o` and `mem_last_o` are 0.
- R2: A `start_i` pulse sampled while `mem_valid_o` is 0 latches `stripe_i`. In the next cycle `mem_valid_o` is 1 and `mem_chip_o` is 0.
- R3: Members come out in ascending chip order 0 to NUM_CHIPS-1, and the chip advances by one on each cycle where both `mem_valid_o` and `mem_ready_i` are 1. While `mem_valid_o` is 1 and `mem_ready_i` is 0, all member outputs hold their values.
- R4: `mem_last_o` is 1 only on chip NUM_CHIPS-1, which is the parity member. After that member's handshake, `mem_valid_o` is 0 in the next cycle.
- R5: A `start_i` pulse while `mem_valid_o` is 1 is ignored. The stripe in progress continues unchanged, and no extra stripe follows it.
- R6: For stripe s and chip c, `mem_layer_o` equals (s + c) mod NUM_LAYERS.
- R7: `mem_msb_o` is 1 (MSB page) when the parity of (s + c) equals bit log2(NUM_LAYERS) of s. Otherwise it is 0 (LSB page).
- R8: `mem_block_o` equals floor(s / (2·NUM_LAYERS)), and it is the same for all members of a stripe.
- R9: Every stripe holds exactly NUM_CHIPS/2 MSB members and NUM_CHIPS/2 LSB members.
- R10: Over the 2·NUM_LAYERS stripes of an aligned run, each chip uses each (layer, page type) pair exactly once.
- R11: When NUM_LAYERS ≥ NUM_CHIPS, the members of one stripe sit on NUM_CHIPS distinct layers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a stripe; taken only while idle |
| stripe_i | input | STRIPE_W | Stripe number sampled with `start_i` |
| mem_valid_o | output | 1 | A member address is presented |
| mem_ready_i | input | 1 | Consumer accepts the presented member |
| mem_chip_o | output | log2(NUM_CHIPS) | Chip of the member |
| mem_block_o | output | STRIPE_W-log2(NUM_LAYERS)-1 | Block inside the chip |
| mem_layer_o | output | log2(NUM_LAYERS) | Wordline layer |
| mem_msb_o | output | 1 | 1 = MSB page, 0 = LSB page |
| mem_last_o | output | 1 | Parity member (final chip) |

## Verification
The bench runs one full aligned run of 2·NUM_LAYERS stripes and tallies the slots actually used. A mapper whose page-type phase does not flip between the two halves would reuse half the slots twice and leave the other half empty, which breaks R10. The bench also uses stripes near the top of the index range and stripes just past a half boundary. A design that computed the block from the wrong bits, or wrapped the layer sum incorrectly, would show a wrong block or layer there. Finally, the bench stalls the consumer right after launch and pulses start in the middle of a stripe. A sequencer that advances without a handshake, or that relatches the stripe number while busy, would then emit a skipped chip or a foreign stripe's addresses.

// File: rtl/smap_pkg.sv
// Shared types for the stripe mapper.
// Assumes nothing beyond standard SystemVerilog enums.
package smap_pkg;

    // Sequencer phase: idle waiting for start, or emitting members.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_EMIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/smap_seq.sv
// Stripe sequencer: latches a stripe number on start while idle, then walks
// the chip index from 0 to NUM_CHIPS-1, advancing on each accepted handshake.
// Assumes NUM_CHIPS >= 2. Start pulses while emitting are ignored.
module smap_seq
    import smap_pkg::*;
#(
    parameter int NUM_CHIPS = 16,
    parameter int STRIPE_W  = 16,
    localparam int CHIP_W   = $clog2(NUM_CHIPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [STRIPE_W-1:0] stripe_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic                last_o,
    output logic [CHIP_W-1:0]   chip_o,
    output logic [STRIPE_W-1:0] stripe_o
);

    localparam logic [CHIP_W-1:0] TOP_CHIP = CHIP_W'(NUM_CHIPS - 1);

    seq_state_e          state_q;
    logic [CHIP_W-1:0]   chip_q;
    logic [STRIPE_W-1:0] stripe_q;

    // Phase, chip counter and latched stripe number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            chip_q   <= '0;
            stripe_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        stripe_q <= stripe_i;
                        chip_q   <= '0;
                        state_q  <= SEQ_EMIT;
                    end
                end
                SEQ_EMIT: begin
                    if (ready_i) begin
                        if (chip_q == TOP_CHIP) begin
                            chip_q  <= '0;
                            state_q <= SEQ_IDLE;
                        end else begin
                            chip_q <= chip_q + CHIP_W'(1);
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output view of the sequencer state.
    always_comb begin
        valid_o  = (state_q == SEQ_EMIT);
        last_o   = (state_q == SEQ_EMIT) && (chip_q == TOP_CHIP);
        chip_o   = chip_q;
        stripe_o = stripe_q;
    end

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && chip_o == '0)); // R2

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(chip_o) && $stable(stripe_o))); // R3

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !last_o) |=> (valid_o && chip_o == $past(chip_o) + CHIP_W'(1))); // R3

    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> !valid_o); // R4

    AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !(ready_i && last_o)) |=> $stable(stripe_o)); // R5

endmodule

// File: rtl/smap_place.sv
// Placement calculator: maps (stripe, chip) to block, layer and page type.
// The layer rotates as (stripe + chip) mod NUM_LAYERS. The page type
// alternates with the parity of that sum, and its phase flips between the
// two halves of each 2*NUM_LAYERS stripe run.
// Assumes NUM_LAYERS is a power of two >= 2 and STRIPE_W > log2(NUM_LAYERS)+1.
module smap_place #(
    parameter int NUM_CHIPS  = 16,
    parameter int NUM_LAYERS = 64,
    parameter int STRIPE_W   = 16,
    localparam int CHIP_W    = $clog2(NUM_CHIPS),
    localparam int LAYER_W   = $clog2(NUM_LAYERS),
    localparam int BLOCK_W   = STRIPE_W - LAYER_W - 1
) (
    input  logic [STRIPE_W-1:0] stripe_i,
    input  logic [CHIP_W-1:0]   chip_i,
    output logic [BLOCK_W-1:0]  block_o,
    output logic [LAYER_W-1:0]  layer_o,
    output logic                msb_o
);

    logic [LAYER_W-1:0] chip_mod;

    // Reduce the chip number modulo the layer count; the width relation picks the form.
    generate
        if (CHIP_W > LAYER_W) begin : g_chip_trunc
            assign chip_mod = chip_i[LAYER_W-1:0];
        end else begin : g_chip_ext
            assign chip_mod = LAYER_W'(chip_i);
        end
    endgenerate

    // Rotated layer, phase-flipped page type and block of the run.
    always_comb begin
        layer_o = stripe_i[LAYER_W-1:0] + chip_mod;
        msb_o   = ~(stripe_i[0] ^ chip_mod[0] ^ stripe_i[LAYER_W]);
        block_o = stripe_i[STRIPE_W-1:LAYER_W+1];
    end

endmodule

// File: rtl/rl_stripe_mapper.sv
// Layer-interleaved parity stripe mapper, top level.
// Emits NUM_CHIPS member page addresses per stripe over a valid/ready stream;
// the final chip carries the parity page and raises the last flag.
// Assumes NUM_CHIPS is even and NUM_LAYERS is a power of two >= 2.
module rl_stripe_mapper #(
    parameter int NUM_CHIPS  = 16,
    parameter int NUM_LAYERS = 64,
    parameter int STRIPE_W   = 16,
    localparam int CHIP_W    = $clog2(NUM_CHIPS),
    localparam int LAYER_W   = $clog2(NUM_LAYERS),
    localparam int BLOCK_W   = STRIPE_W - LAYER_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [STRIPE_W-1:0] stripe_i,
    output logic                mem_valid_o,
    input  logic                mem_ready_i,
    output logic [CHIP_W-1:0]   mem_chip_o,
    output logic [BLOCK_W-1:0]  mem_block_o,
    output logic [LAYER_W-1:0]  mem_layer_o,
    output logic                mem_msb_o,
    output logic                mem_last_o
);

    logic [STRIPE_W-1:0] cur_stripe;
    logic [CHIP_W-1:0]   cur_chip;

    smap_seq #(
        .NUM_CHIPS (NUM_CHIPS),
        .STRIPE_W  (STRIPE_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stripe_i (stripe_i),
        .ready_i  (mem_ready_i),
        .valid_o  (mem_valid_o),
        .last_o   (mem_last_o),
        .chip_o   (cur_chip),
        .stripe_o (cur_stripe)
    );

    smap_place #(
        .NUM_CHIPS  (NUM_CHIPS),
        .NUM_LAYERS (NUM_LAYERS),
        .STRIPE_W   (STRIPE_W)
    ) u_place (
        .stripe_i (cur_stripe),
        .chip_i   (cur_chip),
        .block_o  (mem_block_o),
        .layer_o  (mem_layer_o),
        .msb_o    (mem_msb_o)
    );

    // Chip number goes straight to the port.
    assign mem_chip_o = cur_chip;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid_o |-> !mem_last_o); // R1

    AST_LAYER_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i && !mem_last_o) |=>
            (mem_layer_o == $past(mem_layer_o) + LAYER_W'(1))); // R6

    AST_PAGE_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i && !mem_last_o) |=> (mem_msb_o != $past(mem_msb_o))); // R7

    AST_BLOCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i && !mem_last_o) |=> $stable(mem_block_o)); // R8

endmodule

// File: tb/rl_stripe_mapper_bench.sv
// Bench for the stripe mapper: a behavioural queue of expected members,
// compared with the outputs on every clock.
module rl_stripe_mapper_bench;

    localparam int NCH = 16;
    localparam int NL  = 64;
    localparam int SW  = 16;
    localparam int CW  = $clog2(NCH);
    localparam int LW  = $clog2(NL);
    localparam int BW  = SW - LW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [SW-1:0] stripe_i = '0;
    logic          mem_ready_i = 1'b0;
    logic          mem_valid_o;
    logic [CW-1:0] mem_chip_o;
    logic [BW-1:0] mem_block_o;
    logic [LW-1:0] mem_layer_o;
    logic          mem_msb_o;
    logic          mem_last_o;

    always #5 clk = ~clk;

    rl_stripe_mapper #(
        .NUM_CHIPS  (NCH),
        .NUM_LAYERS (NL),
        .STRIPE_W   (SW)
    ) u_rl_stripe_mapper (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stripe_i    (stripe_i),
        .mem_valid_o (mem_valid_o),
        .mem_ready_i (mem_ready_i),
        .mem_chip_o  (mem_chip_o),
        .mem_block_o (mem_block_o),
        .mem_layer_o (mem_layer_o),
        .mem_msb_o   (mem_msb_o),
        .mem_last_o  (mem_last_o)
    );

    typedef struct {
        int chip;
        int block;
        int layer;
        int msb;
        int last;
    } member_t;

    member_t     expq[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [15:0] lfsr = 16'hACE1;
    int          slot_use [NCH][NL][2];
    int          stripe_msb;
    bit          layer_seen [NL];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected members of stripe s from the requirement formulas (R6, R7, R8, R4).
    task automatic push_stripe(input int s);
        for (int c = 0; c < NCH; c++) begin
            member_t e;
            e.chip  = c;
            e.layer = (s + c) % NL;
            e.msb   = (((s + c) % 2) == ((s / NL) % 2)) ? 1 : 0;
            e.block = s / (2 * NL);
            e.last  = (c == NCH - 1) ? 1 : 0;
            expq.push_back(e);
        end
        stripe_msb = 0;
        for (int l = 0; l < NL; l++) layer_seen[l] = 1'b0;
    endtask

    // Compare current outputs with the head of the model queue.
    task automatic compare();
        check(mem_valid_o == (expq.size() != 0), "R3", "valid",
              int'(mem_valid_o), int'(expq.size() != 0));
        if (mem_valid_o && expq.size() != 0) begin
            member_t e;
            e = expq[0];
            check(int'(mem_chip_o) == e.chip, (expq.size() == NCH) ? "R2" : "R3",
                  "chip", int'(mem_chip_o), e.chip);
            check(int'(mem_layer_o) == e.layer, "R6", "layer", int'(mem_layer_o), e.layer);
            check(int'(mem_msb_o) == e.msb, "R7", "msb", int'(mem_msb_o), e.msb);
            check(int'(mem_block_o) == e.block, "R8", "block", int'(mem_block_o), e.block);
            check(int'(mem_last_o) == e.last, "R4", "last", int'(mem_last_o), e.last);
        end
    endtask

    // One clock: compare at the falling edge, then drive inputs and advance the model.
    task automatic step(input bit st, input int s, input bit rdy);
        int distinct;
        @(negedge clk);
        compare();
        start_i     = st;
        stripe_i    = SW'(s);
        mem_ready_i = rdy;
        if (mem_valid_o && rdy) begin
            slot_use[mem_chip_o][mem_layer_o][mem_msb_o]++;
            stripe_msb += int'(mem_msb_o);
            layer_seen[mem_layer_o] = 1'b1;
            if (mem_last_o) begin
                check(stripe_msb == NCH / 2, "R9", "msb members", stripe_msb, NCH / 2);
                distinct = 0;
                for (int l = 0; l < NL; l++) distinct += int'(layer_seen[l]);
                check(distinct == NCH, "R11", "distinct layers", distinct, NCH);
            end
            if (expq.size() != 0) void'(expq.pop_front());
        end else if (st && !mem_valid_o) begin
            push_stripe(s);
        end
    endtask

    // Run one stripe. Mode 0: pseudo-random ready. Mode 1: stall after launch.
    // Mode 2: start pulses with another index while busy (R5).
    task automatic run_stripe(input int s, input int mode);
        int n;
        bit r;
        bit st;
        step(1'b1, s, 1'b1);
        n = 0;
        while (expq.size() != 0 && n < 200) begin
            r    = lfsr[0] | lfsr[1];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            st   = 1'b0;
            if (mode == 1 && n < 5) r = 1'b0;
            if (mode == 2 && (n == 3 || n == 7)) st = 1'b1;
            step(st, st ? (s ^ 32'h5A5A) : s, r);
            n++;
        end
    endtask

    initial begin
        int bad;
        for (int c = 0; c < NCH; c++)
            for (int l = 0; l < NL; l++)
                for (int t = 0; t < 2; t++) slot_use[c][l][t] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_valid_o == 1'b0, "R1", "valid in reset", int'(mem_valid_o), 0);
        check(mem_last_o == 1'b0, "R1", "last in reset", int'(mem_last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid_o == 1'b0, "R1", "valid after reset", int'(mem_valid_o), 0);

        // One full aligned run of 2*NL stripes (R10), with stall and busy-start cases.
        run_stripe(0, 1);
        for (int s = 1; s < 2 * NL; s++) run_stripe(s, (s == 5 || s == 70) ? 2 : 0);
        bad = 0;
        for (int c = 0; c < NCH; c++)
            for (int l = 0; l < NL; l++)
                for (int t = 0; t < 2; t++)
                    if (slot_use[c][l][t] != 1) bad++;
        check(bad == 0, "R10", "slots not used exactly once", bad, 0);

        // Boundary stripes: top of range, half boundary, later blocks.
        run_stripe(16'hFFFF, 0);
        run_stripe(NL, 1);
        run_stripe(NL - 1, 0);
        run_stripe(16'h00BF, 2);
        run_stripe(16'h1234, 0);
        step(1'b0, 0, 1'b1);
        step(1'b0, 0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule